// File: doc/BRIEF.md
# Expert Token Permuter with Aligned Segments

This block sorts a stream of tokens by expert index. It does the sorting and the padding in a single pass. Software first loads how many tokens each expert will receive. The block then computes the start row of every expert's segment in a padded buffer. Each segment's length is that expert's count rounded up to the alignment, which is 16 by default. The segments sit one after another in ascending expert order.

In forward mode, the block assigns each arriving token its destination row at the moment it arrives. That row is the segment start plus the number of tokens that expert has already received. The block emits the row address together with the payload and stores it in a per-token map. After the last counted token, it emits all-zero pad rows that fill the tail of every segment.

In reverse mode, the block replays the map in original token order. For each token it emits the padded-buffer row that holds the token and the token's original index. Pad rows are skipped, so the caller can gather the tokens back into their original order.

Top module: `ep_permute_pad`

## Requirements
- R1: In forward mode, a token of expert e that is the k-th such token to arrive (counting from 0) is emitted with out_addr = base(e) + k. As a result, each expert's tokens occupy consecutive rows in arrival order.
- R2: base(0) = 0, and base(e+1) = base(e) + padded(e), where padded(e) is the loaded count of expert e rounded up to a multiple of ALIGN (16). As a result, every segment starts on a multiple of 16.
- R3: After the last counted token, the block emits one row for every padded position that no token filled, with out_pad = 1, out_data = 0 and out_tok = 0. The emission runs in ascending expert order and ascending row order. No other rows are emitted.
- R4: An expert with a count of 0 gets a zero-length segment and produces no rows.
- R5: In reverse mode, for i = 0 .. N-1 in order, the block emits out_addr equal to the row that token i was written to in forward mode, with out_tok = i, out_pad = 0 and out_data = 0.
- R6: In forward mode, a token row carries the input payload unchanged and out_tok set to the token's arrival index.
- R7: After reset, busy and out_valid are 0 and all loaded counts are 0.
- R8: busy rises in the cycle after start is sampled and falls once the last row has been emitted. out_valid is never 1 while busy is 0.
- R9: While the block is idle, tok_valid is ignored and no row is emitted. In the cycle after the block is idle, out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_we | input | 1 | Load a per-expert token count (idle only) |
| cnt_expert | input | EXP_W | Expert whose count is loaded |
| cnt_value | input | CNT_W | Token count for that expert |
| start | input | 1 | Begin a pass (sampled while idle) |
| mode | input | 1 | 0 = forward scatter with padding, 1 = reverse replay |
| tok_valid | input | 1 | Forward token present |
| tok_expert | input | EXP_W | Expert index of the token |
| tok_data | input | DATA_W | Token payload |
| busy | output | 1 | A pass is in progress |
| out_valid | output | 1 | A row is presented this cycle |
| out_pad | output | 1 | Row is padding |
| out_addr | output | ADDR_W | Row in the padded buffer (write in forward, read in reverse) |
| out_tok | output | TOK_W | Original token index |
| out_data | output | DATA_W | Row payload (zero for pad and reverse rows) |

## Verification
The bench targets five corner cases:
- An interleaved arrival order, with empty experts and with counts of 16 and 17 that fall on either side of a boundary. A design that adds the raw count of a lower expert instead of its padded count would place every later segment off alignment.
- An expert count that is exactly a multiple of 16. An off-by-one in the pad fill would emit an extra pad row or overwrite the next segment.
- A pass in which every count is zero. A design could hang or emit stray pad rows here.
- A single expert holding the maximum number of tokens.
- Eight one-token experts, where almost every row is padding.

Every forward pass is followed by a reverse pass. A map entry stored under the wrong token index shows up as a restored payload that does not match the original.

// File: rtl/ep_pkg.sv
package ep_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FWD  = 2'd1,
      ST_PAD  = 2'd2,
      ST_REV  = 2'd3
   } ep_state_t;
endpackage

// File: rtl/ep_offsets.sv
module ep_offsets #(
   parameter int NUM_EXP = 8,
   parameter int CNT_W   = 7,
   parameter int ADDR_W  = 8,
   parameter int ALIGN   = 16
) (
   input  logic [CNT_W-1:0]  cnt       [NUM_EXP],
   output logic [ADDR_W-1:0] seg_base  [NUM_EXP],
   output logic [ADDR_W-1:0] seg_len   [NUM_EXP],
   output logic [ADDR_W-1:0] total_tok
);
   localparam int LG = (ALIGN > 1) ? $clog2(ALIGN) : 0;

   logic [ADDR_W-1:0] acc_base [NUM_EXP+1];
   logic [ADDR_W-1:0] acc_tok  [NUM_EXP+1];

   assign acc_base[0] = '0;
   assign acc_tok[0]  = '0;

   for (genvar e = 0; e < NUM_EXP; e++) begin : g_exp
      logic [ADDR_W-1:0] ext;
      assign ext = ADDR_W'(cnt[e]);
      if (ALIGN == 1) begin : g_plain
         assign seg_len[e] = ext;
      end else begin : g_round
         assign seg_len[e] = ((ext + ADDR_W'(ALIGN - 1)) >> LG) << LG;
      end
      assign seg_base[e]   = acc_base[e];
      assign acc_base[e+1] = acc_base[e] + seg_len[e];
      assign acc_tok[e+1]  = acc_tok[e] + ext;
   end

   assign total_tok = acc_tok[NUM_EXP];
endmodule

// File: rtl/ep_map.sv
module ep_map #(
   parameter int IDX_W  = 6,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [ADDR_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [ADDR_W-1:0] rdata
);
   localparam int DEPTH = 1 << IDX_W;

   logic [ADDR_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[widx] <= wdata;
   end

   assign rdata = mem[ridx];
endmodule

// File: rtl/ep_permute_pad.sv
module ep_permute_pad
   import ep_pkg::*;
#(
   parameter int NUM_EXP = 8,
   parameter int DATA_W  = 32,
   parameter int MAX_TOK = 64,
   parameter int ALIGN   = 16,
   localparam int EXP_W  = $clog2(NUM_EXP),
   localparam int TOK_W  = $clog2(MAX_TOK),
   localparam int CNT_W  = $clog2(MAX_TOK + 1),
   localparam int ADDR_W = $clog2(MAX_TOK + NUM_EXP * (ALIGN - 1) + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_we,
   input  logic [EXP_W-1:0]  cnt_expert,
   input  logic [CNT_W-1:0]  cnt_value,
   input  logic              start,
   input  logic              mode,
   input  logic              tok_valid,
   input  logic [EXP_W-1:0]  tok_expert,
   input  logic [DATA_W-1:0] tok_data,
   output logic              busy,
   output logic              out_valid,
   output logic              out_pad,
   output logic [ADDR_W-1:0] out_addr,
   output logic [TOK_W-1:0]  out_tok,
   output logic [DATA_W-1:0] out_data
);
   if (NUM_EXP < 2 || (NUM_EXP & (NUM_EXP - 1)) != 0) begin : g_bad_exp
      $error("NUM_EXP must be a power of two of at least 2");
   end
   if (ALIGN < 1 || (ALIGN & (ALIGN - 1)) != 0) begin : g_bad_align
      $error("ALIGN must be a power of two");
   end
   if (MAX_TOK < 2) begin : g_bad_tok
      $error("MAX_TOK must be at least 2");
   end

   localparam logic [EXP_W-1:0] LAST_E = EXP_W'(NUM_EXP - 1);

   ep_state_t         state;
   logic [CNT_W-1:0]  counts   [NUM_EXP];
   logic [ADDR_W-1:0] fill     [NUM_EXP];
   logic [ADDR_W-1:0] seg_base [NUM_EXP];
   logic [ADDR_W-1:0] seg_len  [NUM_EXP];
   logic [ADDR_W-1:0] total_tok;
   logic [ADDR_W-1:0] idx;
   logic [EXP_W-1:0]  pe;
   logic [ADDR_W-1:0] tok_dst;
   logic [ADDR_W-1:0] seg_lo, seg_hi;
   logic [ADDR_W-1:0] map_rdata;
   logic              run_end;
   logic              map_we;

   ep_offsets #(
      .NUM_EXP(NUM_EXP), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .ALIGN(ALIGN)
   ) u_offsets (
      .cnt(counts), .seg_base(seg_base), .seg_len(seg_len), .total_tok(total_tok)
   );

   assign run_end = (idx == total_tok);
   assign seg_lo  = seg_base[tok_expert];
   assign seg_hi  = seg_lo + seg_len[tok_expert];
   assign tok_dst = seg_lo + fill[tok_expert];
   assign map_we  = (state == ST_FWD) && !run_end && tok_valid;
   assign busy    = (state != ST_IDLE);

   ep_map #(.IDX_W(TOK_W), .ADDR_W(ADDR_W)) u_map (
      .clk(clk), .we(map_we), .widx(idx[TOK_W-1:0]), .wdata(tok_dst),
      .ridx(idx[TOK_W-1:0]), .rdata(map_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         idx       <= '0;
         pe        <= '0;
         out_valid <= 1'b0;
         out_pad   <= 1'b0;
         out_addr  <= '0;
         out_tok   <= '0;
         out_data  <= '0;
         for (int e = 0; e < NUM_EXP; e++) begin
            counts[e] <= '0;
            fill[e]   <= '0;
         end
      end else begin
         out_valid <= 1'b0;
         out_pad   <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (cnt_we) counts[cnt_expert] <= cnt_value;
               if (start) begin
                  idx <= '0;
                  pe  <= '0;
                  if (mode) begin
                     state <= ST_REV;
                  end else begin
                     state <= ST_FWD;
                     for (int e = 0; e < NUM_EXP; e++) fill[e] <= '0;
                  end
               end
            end
            ST_FWD: begin
               if (run_end) begin
                  state <= ST_PAD;
               end else if (tok_valid) begin
                  out_valid          <= 1'b1;
                  out_addr           <= tok_dst;
                  out_data           <= tok_data;
                  out_tok            <= idx[TOK_W-1:0];
                  fill[tok_expert]   <= fill[tok_expert] + 1'b1;
                  idx                <= idx + 1'b1;
               end
            end
            ST_PAD: begin
               if (fill[pe] < seg_len[pe]) begin
                  out_valid <= 1'b1;
                  out_pad   <= 1'b1;
                  out_addr  <= seg_base[pe] + fill[pe];
                  out_data  <= '0;
                  out_tok   <= '0;
                  fill[pe]  <= fill[pe] + 1'b1;
               end else if (pe == LAST_E) begin
                  state <= ST_IDLE;
               end else begin
                  pe <= pe + 1'b1;
               end
            end
            ST_REV: begin
               if (run_end) begin
                  state <= ST_IDLE;
               end else begin
                  out_valid <= 1'b1;
                  out_addr  <= map_rdata;
                  out_tok   <= idx[TOK_W-1:0];
                  out_data  <= '0;
                  idx       <= idx + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R1: an accepted token lands inside its expert's segment
   p_fwd_in_seg_r1: assert property (@(posedge clk) disable iff (!rst_n)
      map_we |=> (out_valid && out_addr >= $past(seg_lo) && out_addr < $past(seg_hi)));

   // R2: the fill pointer never runs past the padded segment length
   for (genvar e = 0; e < NUM_EXP; e++) begin : g_chk
      p_fill_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (state == ST_FWD || state == ST_PAD) |-> (fill[e] <= seg_len[e]));
   end

   // R3: pad rows carry an all-zero payload
   p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_pad) |-> (out_data == '0));

   // R8: rows appear only during a pass
   p_busy_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> busy);

   // R9: nothing is emitted in the cycle after the idle state
   p_idle_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |=> !out_valid);
endmodule

// File: tb/sim_ep_permute_pad.sv
module sim_ep_permute_pad;
   localparam int NE = 8, DW = 32, MT = 64, AL = 16;
   localparam int EW = 3, TW = 6, CW = 7, AW = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n, cnt_we, start, mode, tok_valid;
   logic [EW-1:0] cnt_expert, tok_expert;
   logic [CW-1:0] cnt_value;
   logic [DW-1:0] tok_data;
   logic          busy, out_valid, out_pad;
   logic [AW-1:0] out_addr;
   logic [TW-1:0] out_tok;
   logic [DW-1:0] out_data;

   ep_permute_pad #(.NUM_EXP(NE), .DATA_W(DW), .MAX_TOK(MT), .ALIGN(AL)) u0 (
      .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .cnt_expert(cnt_expert),
      .cnt_value(cnt_value), .start(start), .mode(mode), .tok_valid(tok_valid),
      .tok_expert(tok_expert), .tok_data(tok_data), .busy(busy),
      .out_valid(out_valid), .out_pad(out_pad), .out_addr(out_addr),
      .out_tok(out_tok), .out_data(out_data)
   );

   typedef struct {
      logic [AW-1:0] addr;
      logic [TW-1:0] tok;
      logic          pad;
      logic [DW-1:0] data;
      string         req;
   } item_t;

   item_t         q[$];
   int            n_chk = 0, n_fail = 0;
   bit            rev_phase = 1'b0;
   logic [DW-1:0] pmem     [256];
   logic [DW-1:0] orig     [MT];
   logic [DW-1:0] restored [MT];
   logic [AW-1:0] eaddr    [MT];
   logic [AW-1:0] obs      [MT];
   int            tag      [MT];
   int            ctab     [NE];
   int            first_tok[NE];

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   // monitor: pops the scoreboard as rows appear
   always @(negedge clk) begin
      item_t it;
      if (rst_n && out_valid) begin
         if (q.size() == 0) begin
            chk(1'b0, "R9 unexpected row", 64'(out_addr), 64'hFFFF);
         end else begin
            it = q.pop_front();
            chk(out_addr == it.addr, it.req, 64'(out_addr), 64'(it.addr));
            chk({out_pad, out_tok, out_data} == {it.pad, it.tok, it.data}, it.req,
                64'({out_pad, out_tok, out_data}), 64'({it.pad, it.tok, it.data}));
            if (!rev_phase) begin
               pmem[out_addr] = out_data;
               if (!out_pad) obs[out_tok] = out_addr;
            end else begin
               restored[out_tok] = pmem[out_addr];
            end
         end
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R8 watchdog: actual hung expected finished");
      summary();
      $finish;
   end

   task automatic build(input int step, output int n);
      int k = 0;
      n = 0;
      for (int e = 0; e < NE; e++) n += ctab[e];
      for (int e = 0; e < NE; e++)
         for (int j = 0; j < ctab[e]; j++) begin
            tag[(k * step) % n] = e;
            k++;
         end
      for (int i = 0; i < n; i++)
         orig[i] = {8'(tag[i] + 1), 8'(i), 16'hBEEF ^ 16'(i * 37)};
   endtask

   task automatic wait_idle();
      for (int c = 0; c < 3000 && busy; c++) @(negedge clk);
      chk(!busy, "R8 busy falls after pass", 64'(busy), 0);
      @(negedge clk);
   endtask

   task automatic run_fwd(input int n, input int gap);
      int base[NE];
      int padded[NE];
      int rank[NE];
      int acc = 0;
      item_t it;
      for (int e = 0; e < NE; e++) begin
         padded[e] = ((ctab[e] + AL - 1) / AL) * AL;
         base[e] = acc;
         acc += padded[e];
         rank[e] = 0;
         first_tok[e] = -1;
      end
      for (int i = 0; i < n; i++) begin
         int e = tag[i];
         if (rank[e] == 0) first_tok[e] = i;
         eaddr[i] = AW'(base[e] + rank[e]);
         rank[e]++;
         it.addr = eaddr[i]; it.tok = TW'(i); it.pad = 1'b0; it.data = orig[i];
         it.req = "R1 R6 token row";
         q.push_back(it);
      end
      for (int e = 0; e < NE; e++)
         for (int j = ctab[e]; j < padded[e]; j++) begin
            it.addr = AW'(base[e] + j); it.tok = '0; it.pad = 1'b1; it.data = '0;
            it.req = "R3 R4 pad row";
            q.push_back(it);
         end
      for (int e = 0; e < NE; e++) begin
         @(negedge clk);
         cnt_we = 1'b1; cnt_expert = EW'(e); cnt_value = CW'(ctab[e]);
      end
      @(negedge clk);
      cnt_we = 1'b0; start = 1'b1; mode = 1'b0;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R8 busy after start", 64'(busy), 1);
      for (int i = 0; i < n; i++) begin
         tok_valid = 1'b1; tok_expert = EW'(tag[i]); tok_data = orig[i];
         @(negedge clk);
         tok_valid = 1'b0;
         repeat (gap) @(negedge clk);
      end
      wait_idle();
      chk(q.size() == 0, "R3 all rows emitted", 64'(q.size()), 0);
      for (int e = 0; e < NE; e++)
         if (first_tok[e] >= 0)
            chk(obs[first_tok[e]] % AL == 0, "R2 segment start aligned",
                64'(obs[first_tok[e]]), 64'(base[e]));
   endtask

   task automatic run_rev(input int n);
      item_t it;
      rev_phase = 1'b1;
      for (int i = 0; i < MT; i++) restored[i] = '0;
      for (int i = 0; i < n; i++) begin
         it.addr = eaddr[i]; it.tok = TW'(i); it.pad = 1'b0; it.data = '0;
         it.req = "R5 reverse row";
         q.push_back(it);
      end
      @(negedge clk);
      start = 1'b1; mode = 1'b1;
      @(negedge clk);
      start = 1'b0; mode = 1'b0;
      wait_idle();
      chk(q.size() == 0, "R5 all reverse rows emitted", 64'(q.size()), 0);
      for (int i = 0; i < n; i++)
         chk(restored[i] == orig[i], "R5 round trip restores token", 64'(restored[i]), 64'(orig[i]));
      rev_phase = 1'b0;
   endtask

   task automatic set_counts(input int c0, input int c1, input int c2, input int c3,
                             input int c4, input int c5, input int c6, input int c7);
      ctab[0] = c0; ctab[1] = c1; ctab[2] = c2; ctab[3] = c3;
      ctab[4] = c4; ctab[5] = c5; ctab[6] = c6; ctab[7] = c7;
   endtask

   initial begin
      int n;
      rst_n = 1'b0; cnt_we = 1'b0; start = 1'b0; mode = 1'b0; tok_valid = 1'b0;
      cnt_expert = '0; cnt_value = '0; tok_expert = '0; tok_data = '0;
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R7 busy at reset", 64'(busy), 0);
      chk(out_valid == 1'b0, "R7 out_valid at reset", 64'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: tokens offered while idle are dropped
      tok_valid = 1'b1; tok_expert = 3'd2; tok_data = 32'hDEAD0001;
      repeat (3) @(negedge clk);
      tok_valid = 1'b0;
      chk(out_valid == 1'b0 && busy == 1'b0, "R9 idle ignores tokens", 64'({busy, out_valid}), 0);
      @(negedge clk);

      // interleaved arrivals, empty experts, counts 16 and 17
      set_counts(3, 0, 16, 17, 1, 0, 0, 5);
      build(11, n);
      run_fwd(n, 0);
      run_rev(n);

      // all experts empty (R4)
      set_counts(0, 0, 0, 0, 0, 0, 0, 0);
      build(1, n);
      run_fwd(n, 0);
      chk(n == 0, "R4 empty pass", 64'(n), 0);
      run_rev(n);

      // one expert with the maximum token count, gapped arrivals
      set_counts(0, 0, 0, 0, 0, 0, 0, 64);
      build(1, n);
      run_fwd(n, 1);
      run_rev(n);

      // exact multiples of 16: no pad rows (R3 boundary)
      set_counts(16, 16, 0, 0, 16, 0, 16, 0);
      build(13, n);
      run_fwd(n, 0);
      run_rev(n);

      // one token per expert: mostly padding
      set_counts(1, 1, 1, 1, 1, 1, 1, 1);
      build(3, n);
      run_fwd(n, 2);
      run_rev(n);

      summary();
      $finish;
   end
endmodule